// File: doc/BRIEF.md
# LED Dimming PWM Generator

This block produces the dimming waveform that a multi-channel LED current driver applies to its channels. A prescaler derives a fixed-rate tick enable from the system clock, nominally 25 kHz, so one tick lasts 40 µs. A programmed cycle length, counted in ticks, sets the dimming frequency. A second programmed value, also in ticks, sets how long the waveform stays high at the start of each cycle. The generated waveform is combined with an external dimming input pin by a logical AND. Either source can therefore be parked at full on, which leaves brightness control to the other.

Software programs the block through a simple write strobe with a register select. It can set the cycle length, the on-time and the role of the device. A device acting as the timing master drives a frame clock on a shared pin so that other drivers can follow its frequency. A device acting as a follower releases that pin. New cycle length and on-time values wait in a holding stage and are taken over only when a cycle ends, so a write never cuts a pulse short or stretches it.

Top module: `led_pwm_dimmer`

## Requirements
- R1: The position counter advances exactly once every CLK_DIV system clocks. With CLK_DIV clocks per tick, one PWM cycle of P ticks lasts P*CLK_DIV clocks.
- R2: The cycle length is an 18-bit tick count. For a programmed value P of 2 or more, each PWM cycle lasts P ticks.
- R3: A programmed cycle length of 0 or 1 behaves as 2 ticks.
- R4: The internal waveform is high for the first min(D, P) ticks of each cycle, where D is the programmed on-time. D = 0 keeps it low for the whole cycle, and D >= P keeps it high for the whole cycle.
- R5: Cycle length and on-time written during a cycle do not change that cycle. They apply from the next cycle start onward.
- R6: pwm_out is the internal waveform ANDed with ext_pwm_in, with no added register delay. If the internal waveform is held high, pwm_out follows ext_pwm_in. If ext_pwm_in is held high, pwm_out follows the internal waveform.
- R7: In master role, frame_clk_oe is 1. frame_clk_out is high for the first floor(P/2) ticks of each cycle and low for the rest, so its rising edge marks the cycle start.
- R8: In follower role, frame_clk_oe is 0 and frame_clk_out is held at 0.
- R9: Register select values are: 0 = cycle length (wdata[17:0]), 1 = on-time (wdata[17:0]), 2 = role (wdata[0], 1 = master). The role takes effect on the clock after the write. A write with select 3 changes nothing.
- R10: After reset the role is follower, the on-time is 0 and the cycle length is 2 ticks. pwm_out, frame_clk_out and frame_clk_oe are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 length, 1 on-time, 2 role) |
| cfg_wdata | input | 18 | Register write data |
| ext_pwm_in | input | 1 | External dimming input, ANDed with the internal waveform |
| pwm_out | output | 1 | Gated dimming waveform to the channel logic |
| frame_clk_out | output | 1 | Frame clock driven to follower devices |
| frame_clk_oe | output | 1 | Output enable for the frame clock pin |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a running cycle. The bench must show that the pulse already under way keeps its old width. It does this by locking onto the rising edge of the exported frame clock in master role and counting clocks from that edge. It writes a new on-time a few clocks into the cycle, then measures that cycle and the one after it separately. The clamp and the full-on and full-off cases come from a sweep over every short cycle length combined with every on-time from zero to past the length.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;

    localparam int unsigned PERIOD_W   = 18;
    localparam int unsigned MIN_PERIOD = 2;
    localparam int unsigned SEL_W      = 2;

    typedef logic [PERIOD_W-1:0] ticks_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_LENGTH = 2'd0,
        SEL_ONTIME = 2'd1,
        SEL_ROLE   = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        ROLE_FOLLOWER = 1'b0,
        ROLE_MASTER   = 1'b1
    } role_e;

    typedef struct packed {
        ticks_t length;
        ticks_t ontime;
    } dim_cfg_t;

    function automatic ticks_t clamp_length(input ticks_t raw);
        if (raw < ticks_t'(MIN_PERIOD)) begin
            return ticks_t'(MIN_PERIOD);
        end
        return raw;
    endfunction

endpackage

// File: rtl/led_dim_tick.sv
module led_dim_tick #(
    parameter int unsigned CLK_DIV = 5000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    generate
        if (CLK_DIV <= 1) begin : g_passthru
            assign tick = 1'b1;
        end else begin : g_div
            logic [CNT_W-1:0] div_cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    div_cnt <= '0;
                end else if (div_cnt == CNT_W'(CLK_DIV - 1)) begin
                    div_cnt <= '0;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
            assign tick = (div_cnt == CNT_W'(CLK_DIV - 1));
        end
    endgenerate

endmodule

// File: rtl/led_dim_regs.sv
module led_dim_regs
    import led_dim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [PERIOD_W-1:0] cfg_wdata,
    input  logic                cycle_end,
    output dim_cfg_t            active,
    output role_e               role
);
    dim_cfg_t pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            role    <= ROLE_FOLLOWER;
        end else if (cfg_we) begin
            unique case (cfg_sel_e'(cfg_sel))
                SEL_LENGTH: pending.length <= cfg_wdata;
                SEL_ONTIME: pending.ontime <= cfg_wdata;
                SEL_ROLE:   role <= role_e'(cfg_wdata[0]);
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active.length <= clamp_length('0);
            active.ontime <= '0;
        end else if (cycle_end) begin
            active.length <= clamp_length(pending.length);
            active.ontime <= pending.ontime;
        end
    end

endmodule

// File: rtl/led_dim_counter.sv
module led_dim_counter
    import led_dim_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  dim_cfg_t active,
    output ticks_t   pos,
    output logic     cycle_end,
    output logic     pwm_int,
    output logic     frame_int
);
    ticks_t last_pos;
    ticks_t half_len;

    assign last_pos  = active.length - 1'b1;
    assign half_len  = active.length >> 1;
    assign cycle_end = tick && (pos == last_pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (cycle_end) begin
            pos <= '0;
        end else if (tick) begin
            pos <= pos + 1'b1;
        end
    end

    assign pwm_int   = (pos < active.ontime);
    assign frame_int = (pos < half_len);

endmodule

// File: rtl/led_pwm_dimmer.sv
module led_pwm_dimmer
    import led_dim_pkg::*;
#(
    parameter int unsigned CLK_DIV = 5000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [17:0]         cfg_wdata,
    input  logic                ext_pwm_in,
    output logic                pwm_out,
    output logic                frame_clk_out,
    output logic                frame_clk_oe
);
    logic     tick;
    logic     cycle_end;
    logic     pwm_int;
    logic     frame_int;
    ticks_t   pos;
    dim_cfg_t active;
    role_e    role;

    led_dim_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    led_dim_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cycle_end (cycle_end),
        .active    (active),
        .role      (role)
    );

    led_dim_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .active    (active),
        .pos       (pos),
        .cycle_end (cycle_end),
        .pwm_int   (pwm_int),
        .frame_int (frame_int)
    );

    assign pwm_out       = pwm_int & ext_pwm_in;
    assign frame_clk_oe  = (role == ROLE_MASTER);
    assign frame_clk_out = frame_int & (role == ROLE_MASTER);

endmodule

// File: rtl/led_pwm_dimmer_chk.sv
module led_pwm_dimmer_chk
    import led_dim_pkg::*;
#(
    parameter int unsigned CLK_DIV = 5000
) (
    input logic     clk,
    input logic     rst,
    input logic     tick,
    input logic     cycle_end,
    input ticks_t   pos,
    input dim_cfg_t active,
    input logic     ext_pwm_in,
    input logic     pwm_out,
    input logic     frame_clk_out,
    input logic     frame_clk_oe
);
    int unsigned since_tick;

    always_ff @(posedge clk) begin
        if (rst || tick) since_tick <= 0;
        else             since_tick <= since_tick + 1;
    end

    p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        tick |-> (since_tick == CLK_DIV - 1));

    p_pos_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        pos < active.length);

    p_length_clamped_r3: assert property (@(posedge clk) disable iff (rst)
        active.length >= ticks_t'(MIN_PERIOD));

    p_cfg_held_mid_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        !cycle_end |=> $stable(active));

    p_gate_by_pin_r6: assert property (@(posedge clk) disable iff (rst)
        pwm_out |-> ext_pwm_in);

    p_follower_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_clk_oe |-> !frame_clk_out);

    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (pos == '0 && active.ontime == '0 && !frame_clk_oe && !pwm_out));

endmodule

bind led_pwm_dimmer led_pwm_dimmer_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .cycle_end     (cycle_end),
    .pos           (pos),
    .active        (active),
    .ext_pwm_in    (ext_pwm_in),
    .pwm_out       (pwm_out),
    .frame_clk_out (frame_clk_out),
    .frame_clk_oe  (frame_clk_oe)
);

// File: tb/led_pwm_dimmer_bench.sv
`timescale 1ns/1ps
module led_pwm_dimmer_bench;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [17:0] cfg_wdata = '0;
    logic        ext_pwm_in = 1'b1;
    logic        pwm_out, frame_clk_out, frame_clk_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    led_pwm_dimmer #(.CLK_DIV(DIV)) u_led_pwm_dimmer (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ext_pwm_in(ext_pwm_in), .pwm_out(pwm_out),
        .frame_clk_out(frame_clk_out), .frame_clk_oe(frame_clk_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 18'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Lock onto a frame clock rising edge, then count one full cycle.
    // If mid_at >= 0, write on-time mid_val after mid_at samples.
    task automatic measure(output int per, output int hi, output int frm,
                           input int mid_at, input int mid_val);
        logic prev;
        @(negedge clk);
        prev = frame_clk_out;
        forever begin
            @(negedge clk);
            if (frame_clk_out && !prev) break;
            prev = frame_clk_out;
        end
        per = 0; hi = 0; frm = 0;
        prev = 1'b1;
        forever begin
            if (frame_clk_out && !prev) break;
            per++;
            hi  += int'(pwm_out);
            frm += int'(frame_clk_out);
            prev = frame_clk_out;
            if (per == mid_at) begin
                cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 18'(mid_val);
            end else begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0;
    endtask

    task automatic run_cfg(input int p, input int d);
        int per, hi, frm, pe, de;
        wr(2'd0, p);
        wr(2'd1, d);
        measure(per, hi, frm, -1, 0);
        measure(per, hi, frm, -1, 0);
        pe = (p < 2) ? 2 : p;
        de = (d < pe) ? d : pe;
        check((p < 2) ? "R3 clamped length" : "R1/R2 cycle length", per, pe * DIV);
        check("R4 on-time", hi, de * DIV);
        check("R7 frame half", frm, (pe / 2) * DIV);
    endtask

    initial begin
        int per, hi, frm;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 pwm_out", int'(pwm_out), 0);
        check("R10 frame_clk_oe", int'(frame_clk_oe), 0);
        check("R10 frame_clk_out", int'(frame_clk_out), 0);
        @(negedge clk); rst = 1'b0;

        // R8 follower: pin released over a window
        repeat (40) begin
            @(negedge clk);
            check("R8 oe low", int'(frame_clk_oe), 0);
            check("R8 frame low", int'(frame_clk_out), 0);
        end

        // R9 role register
        wr(2'd2, 1);
        check("R9 role master", int'(frame_clk_oe), 1);

        // Sweep of short lengths and all on-times (R1 R2 R3 R4 R7)
        for (int p = 0; p <= 8; p++)
            for (int d = 0; d <= p + 2; d++)
                run_cfg(p, d);
        run_cfg(300, 150);
        run_cfg(300, 299);

        // R5: mid-cycle on-time write keeps current pulse
        wr(2'd0, 6); wr(2'd1, 3);
        measure(per, hi, frm, -1, 0);
        measure(per, hi, frm, 2, 1);
        check("R5 old on-time kept", hi, 3 * DIV);
        measure(per, hi, frm, -1, 0);
        check("R5 new on-time applied", hi, 1 * DIV);

        // R9: select 3 write ignored
        wr(2'd3, 5);
        measure(per, hi, frm, -1, 0);
        measure(per, hi, frm, -1, 0);
        check("R9 sel3 length", per, 6 * DIV);
        check("R9 sel3 on-time", hi, 1 * DIV);

        // R6: gating with external pin
        wr(2'd1, 100);
        measure(per, hi, frm, -1, 0);
        measure(per, hi, frm, -1, 0);
        ext_pwm_in = 1'b0; #1;
        check("R6 ext low gates", int'(pwm_out), 0);
        ext_pwm_in = 1'b1; #1;
        check("R6 ext high passes", int'(pwm_out), 1);
        wr(2'd1, 0);
        measure(per, hi, frm, -1, 0);
        measure(per, hi, frm, -1, 0);
        check("R6 internal low dominates", hi, 0);

        // R9/R8: back to follower
        wr(2'd2, 0);
        check("R8 oe released", int'(frame_clk_oe), 0);
        check("R8 frame held low", int'(frame_clk_out), 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule